// File: doc/BRIEF.md
# Vertex Program Store and Sequencer

This block keeps a 512-entry store of 128-bit vertex-program instructions and steps through it. A host-side command port loads code: one command places an auto-incrementing upload pointer, and each following group of four 32-bit word commands fills one instruction at that pointer, after which the pointer advances. Loading and running are independent. A separate command picks the entry ID, and a run command starts execution there, so subroutines can sit at lower IDs than the main program.

While running, the block issues one instruction per cycle to an external arithmetic datapath, together with its ID and a per-component write mask. It resolves branches, calls and returns itself, using a four-deep return stack. It holds a four-component condition register that records whether the last value written to each component was negative, zero or positive. Instructions are gated by a swizzled test against that register, and there is no loop opcode: loops are built from a conditional backward branch. Execution ends on an end flag or at the highest ID, with a one-cycle done pulse. A stack overflow or underflow latches an error and stops the run.

Top module: `vp_sequencer`

## Requirements
- R1: A set-pointer command (op 0, ID in data bits 8:0) loads the upload pointer. Four word commands (op 1), word 0 first, write one instruction at the pointer: word n lands at instruction bits 32n+31:32n. The pointer then increments by one.
- R2: A set-start command (op 2) records the entry ID. A run command (op 3) accepted while idle and error-free issues that ID in the next cycle. Later instructions follow at consecutive IDs unless flow control redirects them. Each issued instruction shows iss_valid high, its ID on iss_pc and its content on iss_inst.
- R3: Execution stops after issuing an instruction whose end flag (bit 96) is set, or after issuing ID 511. done is high for exactly the one cycle after that last issue, and iss_valid is then low.
- R4: The opcode is bits 59:55: 0x10 branch, 0x11 call, 0x12 return. Branch and call targets are bits 74:66, a field shared with a source operand. With the test disabled, all three are always taken.
- R5: Bit 14 enables the condition test. Bits 13:11 hold the test code (0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always). Bits 10:3 hold four 2-bit component selectors (0=x..3=w) for result lanes x, y, z, w, taken from the high end. A flow-control instruction is taken when any lane passes.
- R6: A non-flow-control instruction issues with iss_wmask bit i set when lane i passes (bit 0 = x), or with all four bits set when the test is disabled. Flow-control instructions issue with a mask of 0.
- R7: When bit 15 is set on a non-flow-control instruction, each lane enabled in its mask takes a class from res_sign/res_zero: less if sign, otherwise equal if zero, otherwise greater. The new class is visible to the next instruction. cc_flags exposes lane i at bits 3i+2:3i as {greater, equal, less}.
- R8: A taken call pushes its own ID plus one. A taken return resumes at the most recently pushed ID. The stack holds four entries.
- R9: A taken call with four entries stacked, or a taken return with none, sets err. The faulting instruction is the last one issued and no done pulse follows. err stays set, and run commands are ignored until reset.
- R10: After reset: no issue, done and err low, every condition lane equal (cc_flags = 0x492), pointers and stack cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set pointer, 1 upload word, 2 set start, 3 run |
| cmd_data | input | 32 | Command payload |
| res_sign | input | 4 | Per-lane negative flag of the datapath result for the issued instruction |
| res_zero | input | 4 | Per-lane zero flag of the datapath result for the issued instruction |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_pc | output | 9 | ID of the issued instruction |
| iss_inst | output | 128 | Issued instruction |
| iss_wmask | output | 4 | Per-lane write enable after the condition test |
| cc_flags | output | 12 | Condition register, three class bits per lane |
| done | output | 1 | One-cycle pulse after a normal stop |
| err | output | 1 | Sticky return-stack fault |

## Verification
The main run is a program that combines all flow-control forms: a taken and an untaken conditional branch, a call and return pair, and a three-pass loop closed by a not-equal backward branch. Its data feed changes the result classes between passes. A wrong stack pop, a wrong target field or a misread test code each leave a different trace of issued IDs. Write masks are checked under identity, broadcast and mixed swizzles over a condition register holding less, equal and greater lanes at once, which tells a swapped selector from a wrong code. Short runs cover the auto-incrementing upload, a stop at the highest ID, and the two stack faults.

// File: rtl/vp_seq_pkg.sv
// Package: shared constants, command codes and condition class type for the
// vertex program sequencer. Field positions are bit indices in the 128-bit
// instruction (word n occupies bits 32n+31:32n).
package vp_seq_pkg;
    localparam int WORD_W   = 32;
    localparam int INST_W   = 128;
    localparam int LANES    = 4;

    // word 0 control fields
    localparam int CC_UPD_BIT  = 15;
    localparam int CC_TEN_BIT  = 14;
    localparam int CC_CODE_LO  = 11;
    localparam int CC_SWZ_LO   = 3;
    // opcode in word 1, branch target in word 2, end flag in word 3
    localparam int OPC_LO      = 55;
    localparam int OPC_W       = 5;
    localparam int TGT_LO      = 66;
    localparam int END_BIT     = 96;

    localparam logic [OPC_W-1:0] OPC_BRA = 5'h10;
    localparam logic [OPC_W-1:0] OPC_CAL = 5'h11;
    localparam logic [OPC_W-1:0] OPC_RET = 5'h12;

    typedef enum logic [1:0] {
        CMD_SET_PTR   = 2'd0,
        CMD_WORD      = 2'd1,
        CMD_SET_START = 2'd2,
        CMD_RUN       = 2'd3
    } cmd_e;

    // Sign/zero class of one condition lane, one-hot.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } ccls_t;

    localparam ccls_t CLS_EQ = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/vp_upload_ram.sv
// Module: upload pointer, word staging and instruction store.
// Assumes words of one instruction arrive in order 0..3; a set-pointer
// command restarts the word count. Read port is asynchronous.
module vp_upload_ram
    import vp_seq_pkg::*;
#(
    parameter int ID_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [ID_W-1:0]   rd_addr,
    output logic [INST_W-1:0] rd_inst
);
    localparam int DEPTH  = 1 << ID_W;
    localparam int WPI    = INST_W / WORD_W;
    localparam int WIDX_W = $clog2(WPI);

    logic [ID_W-1:0]                up_ptr;
    logic [WIDX_W-1:0]              word_idx;
    logic [(WPI-1)*WORD_W-1:0]      stage;
    logic [INST_W-1:0]              mem [DEPTH];
    logic                           is_word;
    logic                           last_word;

    assign is_word   = cmd_valid && (cmd_op == CMD_WORD);
    assign last_word = (word_idx == WIDX_W'(WPI - 1));

    // Pointer and staging: set-pointer reloads, last word advances pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_ptr   <= '0;
            word_idx <= '0;
            stage    <= '0;
        end else if (cmd_valid && cmd_op == CMD_SET_PTR) begin
            up_ptr   <= cmd_data[ID_W-1:0];
            word_idx <= '0;
        end else if (is_word) begin
            if (last_word) begin
                word_idx <= '0;
                up_ptr   <= up_ptr + 1'b1;
            end else begin
                stage[word_idx*WORD_W +: WORD_W] <= cmd_data;
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    // Store write: the complete instruction commits with its last word.
    always_ff @(posedge clk) begin
        if (is_word && last_word)
            mem[up_ptr] <= {cmd_data, stage};
    end

    // Fetch port.
    assign rd_inst = mem[rd_addr];
endmodule

// File: rtl/vp_cond_unit.sv
// Module: condition register, swizzled per-lane test and update.
// Assumes the datapath reports sign/zero of the issued result in the same
// cycle. Lane i of the result reads condition lane swz[i].
module vp_cond_unit
    import vp_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_en,
    input  logic [2:0]         code,
    input  logic [7:0]         swz,
    input  logic               upd_en,
    input  logic [LANES-1:0]   res_sign,
    input  logic [LANES-1:0]   res_zero,
    output logic [LANES-1:0]   wmask,
    output logic               any_pass,
    output logic [3*LANES-1:0] cc_flags
);
    ccls_t            cc [LANES];
    logic [LANES-1:0] lane_pass;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [1:0] sel;
        ccls_t      src;
        // Select the swizzled condition lane and compare it with the code.
        assign sel          = swz[(LANES-1-i)*2 +: 2];
        assign src          = cc[sel];
        assign lane_pass[i] = |(code & {src.gt, src.eq, src.lt});
        assign cc_flags[i*3 +: 3] = cc[i];

        // Lane update: record class of the new value when written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cc[i] <= CLS_EQ;
            else if (upd_en && wmask[i])
                cc[i] <= '{gt: !res_sign[i] && !res_zero[i],
                           eq: !res_sign[i] && res_zero[i],
                           lt: res_sign[i]};
        end
    end

    assign wmask    = test_en ? lane_pass : '1;
    assign any_pass = test_en ? (|lane_pass) : 1'b1;
endmodule

// File: rtl/vp_call_stack.sv
// Module: return-address stack. Assumes the caller never pushes when full
// nor pops when empty; it uses full/empty to detect those faults itself.
module vp_call_stack #(
    parameter int DEPTH = 4,
    parameter int AW_D  = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [AW_D-1:0] push_data,
    output logic [AW_D-1:0] top,
    output logic            full,
    output logic            empty
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW_D-1:0] ent [DEPTH];
    logic [PW-1:0]   cnt;
    logic [PW-1:0]   cnt_m1;

    assign cnt_m1 = cnt - 1'b1;
    assign full   = (cnt == PW'(DEPTH));
    assign empty  = (cnt == '0);
    assign top    = ent[cnt_m1[IW-1:0]];

    // Fill level: up on push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push)
            cnt <= cnt + 1'b1;
        else if (pop)
            cnt <= cnt_m1;
    end

    // Entry store: write the pushed address at the current level.
    always_ff @(posedge clk) begin
        if (push)
            ent[cnt[IW-1:0]] <= push_data;
    end
endmodule

// File: rtl/vp_sequencer.sv
// Module: top of the vertex program store and sequencer. Holds the program
// counter and run state, decodes flow control and ties the store, the
// condition unit and the return stack together. Assumes one instruction is
// issued per cycle and the datapath returns result flags combinationally.
module vp_sequencer
    import vp_seq_pkg::*;
#(
    parameter int ID_W        = 9,
    parameter int STACK_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [WORD_W-1:0]    cmd_data,
    input  logic [LANES-1:0]     res_sign,
    input  logic [LANES-1:0]     res_zero,
    output logic                 iss_valid,
    output logic [ID_W-1:0]      iss_pc,
    output logic [INST_W-1:0]    iss_inst,
    output logic [LANES-1:0]     iss_wmask,
    output logic [3*LANES-1:0]   cc_flags,
    output logic                 done,
    output logic                 err
);
    localparam logic [ID_W-1:0] LAST_ID = '1;

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e              state;
    logic [ID_W-1:0]  pc;
    logic [ID_W-1:0]  start_id;
    logic [INST_W-1:0] inst;
    logic [OPC_W-1:0] opc;
    logic             is_bra, is_cal, is_ret, is_ctrl;
    logic             running, taken;
    logic             do_push, do_pop, fault, stop_ok;
    logic [ID_W-1:0]  target, stk_top, nxt_pc;
    logic             stk_full, stk_empty;
    logic [LANES-1:0] cond_mask;
    logic             cond_any;

    vp_upload_ram #(.ID_W(ID_W)) i_ram (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rd_addr(pc), .rd_inst(inst)
    );

    vp_cond_unit i_cond (
        .clk(clk), .rst_n(rst_n),
        .test_en(inst[CC_TEN_BIT]),
        .code(inst[CC_CODE_LO +: 3]),
        .swz(inst[CC_SWZ_LO +: 8]),
        .upd_en(running && inst[CC_UPD_BIT] && !is_ctrl),
        .res_sign(res_sign), .res_zero(res_zero),
        .wmask(cond_mask), .any_pass(cond_any),
        .cc_flags(cc_flags)
    );

    vp_call_stack #(.DEPTH(STACK_DEPTH), .AW_D(ID_W)) i_stack (
        .clk(clk), .rst_n(rst_n),
        .push(do_push && !stk_full), .pop(do_pop && !stk_empty),
        .push_data(pc + 1'b1), .top(stk_top),
        .full(stk_full), .empty(stk_empty)
    );

    // Decode: opcode class and the target field shared with a source operand.
    always_comb begin
        opc     = inst[OPC_LO +: OPC_W];
        is_bra  = (opc == OPC_BRA);
        is_cal  = (opc == OPC_CAL);
        is_ret  = (opc == OPC_RET);
        is_ctrl = is_bra || is_cal || is_ret;
        target  = inst[TGT_LO +: ID_W];
    end

    // Flow resolution: taken flags, stack faults, stop and next ID.
    always_comb begin
        running = (state == ST_RUN);
        taken   = running && is_ctrl && cond_any;
        do_push = taken && is_cal;
        do_pop  = taken && is_ret;
        fault   = (do_push && stk_full) || (do_pop && stk_empty);
        stop_ok = running && !fault && (inst[END_BIT] || pc == LAST_ID);
        if (taken && (is_bra || is_cal))
            nxt_pc = target;
        else if (taken && is_ret)
            nxt_pc = stk_top;
        else
            nxt_pc = pc + 1'b1;
    end

    // Entry point register, loaded by the set-start command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_id <= '0;
        else if (cmd_valid && cmd_op == CMD_SET_START)
            start_id <= cmd_data[ID_W-1:0];
    end

    // Run state and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
        end else if (state == ST_IDLE) begin
            if (cmd_valid && cmd_op == CMD_RUN && !err) begin
                state <= ST_RUN;
                pc    <= start_id;
            end
        end else if (fault || stop_ok) begin
            state <= ST_IDLE;
        end else begin
            pc <= nxt_pc;
        end
    end

    // Completion pulse and sticky stack fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= stop_ok;
            err  <= err || fault;
        end
    end

    assign iss_valid = running;
    assign iss_pc    = pc;
    assign iss_inst  = inst;
    assign iss_wmask = (running && !is_ctrl) ? cond_mask : '0;
endmodule

// File: rtl/vp_sequencer_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
module vp_sequencer_chk
    import vp_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               iss_valid,
    input logic [INST_W-1:0]  iss_inst,
    input logic [LANES-1:0]   iss_wmask,
    input logic [3*LANES-1:0] cc_flags,
    input logic               done,
    input logic               err
);
    logic ctrl_op;
    assign ctrl_op = (iss_inst[OPC_LO +: OPC_W] == OPC_BRA) ||
                     (iss_inst[OPC_LO +: OPC_W] == OPC_CAL) ||
                     (iss_inst[OPC_LO +: OPC_W] == OPC_RET);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !iss_valid); // R3
    AST_CTRL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && ctrl_op) |-> (iss_wmask == '0)); // R6
    AST_UNCOND_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !ctrl_op && !iss_inst[CC_TEN_BIT]) |-> (iss_wmask == '1)); // R6
    AST_NO_ISSUE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> (iss_wmask == '0)); // R6
    AST_CC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |=> $stable(cc_flags)); // R7
    AST_CC_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cc_flags[2:0]) == 1) && ($countones(cc_flags[5:3]) == 1) &&
        ($countones(cc_flags[8:6]) == 1) && ($countones(cc_flags[11:9]) == 1)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!iss_valid && !done)); // R9
endmodule

bind vp_sequencer vp_sequencer_chk i_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_inst(iss_inst),
    .iss_wmask(iss_wmask), .cc_flags(cc_flags), .done(done), .err(err)
);

// File: tb/test_vp_sequencer.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue the expected issue trace, a monitor pops
// and compares it as the sequencer issues instructions.
module test_vp_sequencer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic [31:0]  cmd_data = '0;
    logic [3:0]   res_sign, res_zero;
    logic         iss_valid;
    logic [8:0]   iss_pc;
    logic [127:0] iss_inst;
    logic [3:0]   iss_wmask;
    logic [11:0]  cc_flags;
    logic         done, err;

    int n_cmp = 0;
    int n_bad = 0;
    int visits = 0;
    logic [12:0] expq [$];

    always #2.5 clk = ~clk;

    vp_sequencer i_vp_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .res_sign(res_sign), .res_zero(res_zero),
        .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_inst(iss_inst),
        .iss_wmask(iss_wmask), .cc_flags(cc_flags), .done(done), .err(err)
    );

    // Datapath model: result classes per issued ID; ID 39 turns zero on its third pass.
    always_comb begin
        res_sign = 4'h0;
        res_zero = 4'h0;
        if (iss_valid && iss_pc == 9'd30) res_sign = 4'hF;
        if (iss_valid && iss_pc == 9'd35) begin res_sign = 4'b0001; res_zero = 4'b0010; end
        if (iss_valid && iss_pc == 9'd39 && visits == 2) res_zero = 4'hF;
    end
    always @(posedge clk) if (iss_valid && iss_pc == 9'd39) visits <= visits + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each issue against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected issue", {19'd0, iss_pc, iss_wmask}, 32'h0);
            end else begin
                logic [12:0] e;
                e = expq.pop_front();
                check({iss_pc, iss_wmask} == e, "R2/R5/R6 issue trace",
                      {19'd0, iss_pc, iss_wmask}, {19'd0, e});
            end
        end
    end

    task automatic push_exp(input int id, input logic [3:0] m);
        expq.push_back({id[8:0], m});
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] d);
        cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [127:0] mk(input logic [4:0] opc, input bit upd, input bit ten,
            input logic [2:0] code, input logic [7:0] swz, input int tgt, input bit endf);
        logic [127:0] v = '0;
        v[15] = upd; v[14] = ten; v[13:11] = code; v[10:3] = swz;
        v[59:55] = opc; v[74:66] = tgt[8:0]; v[96] = endf;
        return v;
    endfunction

    task automatic load(input logic [127:0] v);
        for (int w = 0; w < 4; w++) cmd(2'd1, v[w*32 +: 32]);
    endtask

    // Run from an entry ID and wait for done or err; report which appeared.
    task automatic run_wait(input int start, output bit saw_done, output bit saw_err);
        saw_done = 0; saw_err = 0;
        cmd(2'd2, start);
        cmd(2'd3, 0);
        for (int k = 0; k < 300; k++) begin
            if (done) begin saw_done = 1; break; end
            if (err) begin saw_err = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        bit d, e;
        @(negedge clk);
        do_reset();
        // R10: reset state
        check(!iss_valid && !done && !err, "R10 idle outputs", {iss_valid, done, err}, 0);
        check(cc_flags == 12'h492, "R10 cc all equal", cc_flags, 12'h492);

        // R1/R2/R3: three sequential uploads after one pointer set, end flag stop
        cmd(2'd0, 10);
        load(mk(0, 0, 0, 0, 0, 0, 0));
        load(mk(0, 0, 0, 0, 0, 0, 0));
        load(mk(0, 0, 0, 0, 0, 0, 1));
        push_exp(10, 4'hF); push_exp(11, 4'hF); push_exp(12, 4'hF);
        run_wait(10, d, e);
        check(d && !e, "R3 done after end flag", {d, e}, 2'b10);
        @(negedge clk);
        check(!done && !iss_valid, "R3 done single cycle", {done, iss_valid}, 0);
        check(expq.size() == 0, "R1 all uploaded IDs issued", expq.size(), 0);

        // R3: stop at the highest ID without an end flag
        cmd(2'd0, 511);
        load(mk(0, 0, 0, 0, 0, 0, 0));
        push_exp(511, 4'hF);
        run_wait(511, d, e);
        check(d && !e, "R3 stop at last ID", {d, e}, 2'b10);
        check(expq.size() == 0, "R3 last ID issued", expq.size(), 0);

        // R4/R5/R6/R7/R8: flow control program with loop
        cmd(2'd0, 30);
        load(mk(0, 1, 0, 0, 8'h00, 0, 0));      // 30 update: all less
        load(mk(5'h10, 0, 1, 1, 8'h00, 33, 0)); // 31 branch if less -> 33
        load(mk(0, 0, 0, 0, 8'h00, 0, 0));      // 32 skipped
        load(mk(5'h10, 0, 1, 4, 8'h00, 0, 0));  // 33 branch if greater: not taken
        load(mk(0, 0, 1, 5, 8'h1B, 0, 0));      // 34 not-equal identity
        load(mk(0, 1, 0, 0, 8'h00, 0, 0));      // 35 update: x<0 y=0 z,w>0
        load(mk(0, 0, 1, 6, 8'h1B, 0, 0));      // 36 greater-or-equal identity
        load(mk(0, 0, 1, 1, 8'h04, 0, 0));      // 37 less, swizzle x,x,y,x
        load(mk(5'h11, 0, 0, 0, 8'h00, 50, 0)); // 38 call 50
        load(mk(0, 1, 0, 0, 8'h00, 0, 0));      // 39 loop body update
        load(mk(5'h10, 0, 1, 5, 8'h00, 39, 0)); // 40 back branch if not equal
        load(mk(0, 0, 0, 0, 8'h00, 0, 1));      // 41 end
        cmd(2'd0, 50);
        load(mk(5'h12, 0, 0, 0, 8'h00, 0, 0));  // 50 return
        push_exp(30, 4'hF); push_exp(31, 4'h0); // R4 branch taken
        push_exp(33, 4'h0); push_exp(34, 4'hF); // R5 untaken branch
        push_exp(35, 4'hF); push_exp(36, 4'b1110); // R6 per-lane mask
        push_exp(37, 4'b1011);                  // R5 swizzle
        push_exp(38, 4'h0); push_exp(50, 4'h0); // R8 call/return
        push_exp(39, 4'hF); push_exp(40, 4'h0);
        push_exp(39, 4'hF); push_exp(40, 4'h0);
        push_exp(39, 4'hF); push_exp(40, 4'h0); push_exp(41, 4'hF);
        run_wait(30, d, e);
        check(d && !e, "R8 flow program completes", {d, e}, 2'b10);
        check(expq.size() == 0, "R4 trace consumed", expq.size(), 0);
        check(cc_flags == 12'h492, "R7 cc after zero result", cc_flags, 12'h492);
        check(visits == 3, "R5 loop pass count", visits, 3);

        // R9: fifth nested call overflows
        cmd(2'd0, 60);
        for (int i = 0; i < 5; i++) load(mk(5'h11, 0, 0, 0, 0, 61 + i, 0));
        for (int i = 0; i < 5; i++) push_exp(60 + i, 4'h0);
        run_wait(60, d, e);
        check(e && !d, "R9 overflow error", {d, e}, 2'b01);
        check(expq.size() == 0, "R9 faulting call was last issue", expq.size(), 0);
        run_wait(10, d, e);  // must be ignored: the monitor flags any issue
        check(err && !d && !iss_valid, "R9 run ignored while err", {err, d, iss_valid}, 3'b100);

        // R10/R9: reset clears, then return with empty stack underflows
        do_reset();
        check(!err, "R10 reset clears err", err, 0);
        cmd(2'd0, 70);
        load(mk(5'h12, 0, 0, 0, 0, 0, 0));
        push_exp(70, 4'h0);
        run_wait(70, d, e);
        check(e && !d, "R9 underflow error", {d, e}, 2'b01);
        check(expq.size() == 0, "R9 underflow trace", expq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule